// File: doc/BRIEF.md
# Character LCD Bus Writer

The block takes command bytes and character bytes from a host over a valid/ready handshake and writes them to an 8-bit parallel character-display bus. For every accepted byte it places the byte and the register-select level on the bus, waits a setup interval, raises the enable strobe for a fixed width and drops it. The display latches the byte on that falling edge. The block then holds the bus for a hold interval. It refuses new input for a further recovery interval, because the display ignores anything sent while it executes. The read/write line is always driven to write.

A flag that comes with each byte chooses the destination. A low flag drives the select line low, which targets the display's instruction register. A high flag drives it high, which targets the character register, where ASCII codes are stored. All four intervals are parameters counted in clock cycles. Each one must be at least 1.

The sequencer has five states. IDLE asserts ready and waits. When in_valid is seen in IDLE, the byte is captured and the state moves to SETUP. SETUP lasts SETUP_CYC cycles and then moves to STROBE. STROBE drives the enable high for PULSE_CYC cycles and then moves to HOLD. HOLD lasts HOLD_CYC cycles and then moves to RECOVER. RECOVER lasts WAIT_CYC cycles and then returns to IDLE.

Top module: `lcd_bus_writer`

## Requirements
- R1: After reset: in_ready is 1, lcd_e is 0, lcd_rw is 0, lcd_d is 0x00 and lcd_rs is 0.
- R2: lcd_rw is 0 in every cycle.
- R3: From the cycle after a byte is accepted (in_valid and in_ready both high at a rising edge), lcd_rs equals the accepted in_is_data value: 0 for a command, 1 for character data.
- R4: From the cycle after acceptance, lcd_d equals the accepted byte. It remains stable until the next acceptance.
- R5: Counting the acceptance edge as edge 0, lcd_e is high after edges SETUP_CYC through SETUP_CYC+PULSE_CYC-1 and low at all other times. This gives one pulse of exactly PULSE_CYC cycles.
- R6: After lcd_e falls, lcd_d and lcd_rs stay unchanged for at least HOLD_CYC cycles.
- R7: in_ready is 0 for exactly SETUP_CYC+PULSE_CYC+HOLD_CYC+WAIT_CYC cycles after an acceptance, and then returns to 1.
- R8: in_valid, in_byte and in_is_data have no effect on the bus or on the timing while in_ready is 0.
- R9: While idle, lcd_e is 0 and the bus keeps the last byte and select level that were written.
- R10: If in_valid is held high, the next byte is accepted at the first edge at which in_ready is 1, with no extra idle cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Host offers a byte |
| in_ready | output | 1 | Block can accept a byte |
| in_byte | input | 8 | Byte to write |
| in_is_data | input | 1 | 1 = character data, 0 = command |
| lcd_d | output | 8 | Display data lines |
| lcd_rs | output | 1 | Register select (0 command, 1 data) |
| lcd_rw | output | 1 | Read/write, always 0 (write) |
| lcd_e | output | 1 | Enable strobe; the display latches on its falling edge |

## Verification
A sequencer stuck in the wrong state, or a timer loaded with the wrong count, shows up as a strobe that starts early or late, or has the wrong width. It can also show up as a ready release that comes at the wrong cycle, and the bench checks both cycle by cycle from the acceptance edge. A capture register that reloads while the block is busy changes lcd_d or lcd_rs in the middle of a transfer. The bench exposes this by driving random junk on the host inputs during every busy window. Each of these faults is reported within one transfer of at most SETUP_CYC+PULSE_CYC+HOLD_CYC+WAIT_CYC cycles.

// File: rtl/lcdw_pkg.sv
package lcdw_pkg;
    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_SETUP   = 3'd1,
        ST_STROBE  = 3'd2,
        ST_HOLD    = 3'd3,
        ST_RECOVER = 3'd4
    } lcdw_state_t;
endpackage

// File: rtl/lcdw_timer.sv
module lcdw_timer #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign expired = (cnt == '0);
endmodule

// File: rtl/lcdw_seq.sv
module lcdw_seq
    import lcdw_pkg::*;
#(
    parameter int SETUP_CYC = 2,
    parameter int PULSE_CYC = 4,
    parameter int HOLD_CYC  = 2,
    parameter int WAIT_CYC  = 10,
    parameter int CNT_W     = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic             t_expired,
    output logic             t_load,
    output logic [CNT_W-1:0] t_val,
    output logic             capture,
    output logic             ready,
    output logic             strobe
);
    lcdw_state_t st, st_nx;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= st_nx;
    end

    // transitions and timer loads
    always_comb begin
        st_nx  = st;
        t_load = 1'b0;
        t_val  = '0;
        unique case (st)
            ST_IDLE: if (in_valid) begin
                st_nx  = ST_SETUP;
                t_load = 1'b1;
                t_val  = CNT_W'(SETUP_CYC - 1);
            end
            ST_SETUP: if (t_expired) begin
                st_nx  = ST_STROBE;
                t_load = 1'b1;
                t_val  = CNT_W'(PULSE_CYC - 1);
            end
            ST_STROBE: if (t_expired) begin
                st_nx  = ST_HOLD;
                t_load = 1'b1;
                t_val  = CNT_W'(HOLD_CYC - 1);
            end
            ST_HOLD: if (t_expired) begin
                st_nx  = ST_RECOVER;
                t_load = 1'b1;
                t_val  = CNT_W'(WAIT_CYC - 1);
            end
            ST_RECOVER: if (t_expired) begin
                st_nx = ST_IDLE;
            end
            default: st_nx = ST_IDLE;
        endcase
    end

    // outputs decoded from the state register
    always_comb begin
        ready   = (st == ST_IDLE);
        strobe  = (st == ST_STROBE);
        capture = (st == ST_IDLE) && in_valid;
    end
endmodule

// File: rtl/lcdw_bus_reg.sv
module lcdw_bus_reg #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          capture,
    input  logic [DW-1:0] byte_in,
    input  logic          sel_in,
    output logic [DW-1:0] bus_d,
    output logic          bus_sel
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_d   <= '0;
            bus_sel <= 1'b0;
        end else if (capture) begin
            bus_d   <= byte_in;
            bus_sel <= sel_in;
        end
    end
endmodule

// File: rtl/lcd_bus_writer.sv
module lcd_bus_writer #(
    parameter int SETUP_CYC = 2,
    parameter int PULSE_CYC = 4,
    parameter int HOLD_CYC  = 2,
    parameter int WAIT_CYC  = 10
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       in_valid,
    output logic       in_ready,
    input  logic [7:0] in_byte,
    input  logic       in_is_data,
    output logic [7:0] lcd_d,
    output logic       lcd_rs,
    output logic       lcd_rw,
    output logic       lcd_e
);
    localparam int MAX_AB  = (SETUP_CYC > PULSE_CYC) ? SETUP_CYC : PULSE_CYC;
    localparam int MAX_CD  = (HOLD_CYC > WAIT_CYC) ? HOLD_CYC : WAIT_CYC;
    localparam int MAX_CYC = (MAX_AB > MAX_CD) ? MAX_AB : MAX_CD;
    localparam int CNT_W   = $clog2(MAX_CYC + 1);

    logic             t_load, t_expired, capture;
    logic [CNT_W-1:0] t_val;

    lcdw_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (t_load),
        .load_val (t_val),
        .expired  (t_expired)
    );

    lcdw_seq #(
        .SETUP_CYC (SETUP_CYC),
        .PULSE_CYC (PULSE_CYC),
        .HOLD_CYC  (HOLD_CYC),
        .WAIT_CYC  (WAIT_CYC),
        .CNT_W     (CNT_W)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .t_expired (t_expired),
        .t_load    (t_load),
        .t_val     (t_val),
        .capture   (capture),
        .ready     (in_ready),
        .strobe    (lcd_e)
    );

    lcdw_bus_reg #(.DW(8)) u_bus (
        .clk     (clk),
        .rst_n   (rst_n),
        .capture (capture),
        .byte_in (in_byte),
        .sel_in  (in_is_data),
        .bus_d   (lcd_d),
        .bus_sel (lcd_rs)
    );

    assign lcd_rw = 1'b0;
endmodule

// File: rtl/lcd_bus_writer_chk.sv
module lcd_bus_writer_chk #(
    parameter int PULSE_CYC = 4
) (
    input logic       clk,
    input logic       rst_n,
    input logic       in_valid,
    input logic       in_ready,
    input logic       in_is_data,
    input logic [7:0] lcd_d,
    input logic       lcd_rs,
    input logic       lcd_rw,
    input logic       lcd_e
);
    logic [15:0] e_run;

    always_ff @(posedge clk) begin
        if (!rst_n)     e_run <= '0;
        else if (lcd_e) e_run <= e_run + 1'b1;
        else            e_run <= '0;
    end

    a_r2_rw_write: assert property (@(posedge clk) disable iff (!rst_n)
        lcd_rw == 1'b0);

    a_r3_select_follows_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> (lcd_rs == $past(in_is_data)));

    a_r5_strobe_only_busy: assert property (@(posedge clk) disable iff (!rst_n)
        lcd_e |-> !in_ready);

    a_r5_strobe_width: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(lcd_e) |-> (e_run == 16'(PULSE_CYC)));

    a_r4_bus_stable_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_ready && $past(!in_ready)) |-> ($stable(lcd_d) && $stable(lcd_rs)));

    a_r7_accept_drops_ready: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> !in_ready);

    a_r9_idle_strobe_low: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |-> !lcd_e);
endmodule

bind lcd_bus_writer lcd_bus_writer_chk #(.PULSE_CYC(PULSE_CYC)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .in_is_data (in_is_data),
    .lcd_d      (lcd_d),
    .lcd_rs     (lcd_rs),
    .lcd_rw     (lcd_rw),
    .lcd_e      (lcd_e)
);

// File: tb/lcd_bus_writer_bench.sv
`timescale 1ns/1ps
module lcd_bus_writer_bench;
    localparam int S = 2;
    localparam int P = 3;
    localparam int H = 2;
    localparam int W = 7;
    localparam int T = S + P + H + W;
    localparam int LIMIT = 150000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic       in_ready;
    logic [7:0] in_byte = 8'h00;
    logic       in_is_data = 1'b0;
    logic [7:0] lcd_d;
    logic       lcd_rs, lcd_rw, lcd_e;

    int compared = 0;
    int mismatched = 0;
    int cycles = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    lcd_bus_writer #(.SETUP_CYC(S), .PULSE_CYC(P), .HOLD_CYC(H), .WAIT_CYC(W)) u_lcd_bus_writer (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_byte(in_byte), .in_is_data(in_is_data), .lcd_d(lcd_d),
        .lcd_rs(lcd_rs), .lcd_rw(lcd_rw), .lcd_e(lcd_e));

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles == LIMIT && !done) begin
            mismatched = mismatched + 1;
            $display("FAIL watchdog: actual %0d cycles expected < %0d", cycles, LIMIT);
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    function automatic logic exp_e(int j);
        return (j >= S) && (j < S + P);
    endfunction

    function automatic logic exp_ready(int j);
        return j == T;
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    logic [7:0] last_b = 8'h00;
    logic       last_rs = 1'b0;

    // one transfer, called at a negedge; returns at the negedge where ready is back
    task automatic xfer(input logic [7:0] b, input logic isd, input bit junk);
        in_valid = 1'b1;
        in_byte = b;
        in_is_data = isd;
        while (!in_ready) @(negedge clk);
        @(negedge clk);
        for (int j = 0; j <= T; j++) begin
            check("R7 ready window", 32'(in_ready), 32'(exp_ready(j)));
            check("R5 strobe timing", 32'(lcd_e), 32'(exp_e(j)));
            check("R4 R6 data held", 32'(lcd_d), 32'(b));
            check("R3 R6 select held", 32'(lcd_rs), 32'(isd));
            check("R2 write only", 32'(lcd_rw), 32'd0);
            if (j < T && junk) begin
                // R8: junk while busy
                in_valid = 1'($urandom);
                in_byte = 8'($urandom);
                in_is_data = 1'($urandom);
            end else begin
                in_valid = 1'b0;
            end
            if (j < T) @(negedge clk);
        end
        last_b = b;
        last_rs = isd;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            check("R9 idle strobe low", 32'(lcd_e), 32'd0);
            check("R9 idle ready", 32'(in_ready), 32'd1);
            check("R9 idle data kept", 32'(lcd_d), 32'(last_b));
            check("R9 idle select kept", 32'(lcd_rs), 32'(last_rs));
        end
    endtask

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        check("R1 reset ready", 32'(in_ready), 32'd1);
        check("R1 reset strobe", 32'(lcd_e), 32'd0);
        check("R1 reset rw", 32'(lcd_rw), 32'd0);
        check("R1 reset data", 32'(lcd_d), 32'd0);
        check("R1 reset select", 32'(lcd_rs), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // directed corners
        xfer(8'h01, 1'b0, 1'b0);   // command
        idle(2);
        xfer(8'h41, 1'b1, 1'b1);   // ASCII 'A' as data, junk while busy (R8)
        xfer(8'hFF, 1'b1, 1'b0);   // back-to-back, R10
        xfer(8'h00, 1'b0, 1'b1);   // back-to-back, R10
        idle(3);

        // constrained random traffic
        for (int k = 0; k < 60; k++) begin
            xfer(8'($urandom), 1'($urandom), 1'($urandom));
            idle(int'($urandom % 4));
        end

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule